// File: doc/BRIEF.md
# DMA request channel multiplexer

This block sits between a large pool of peripheral DMA request lines and a small bank of DMA channel request inputs. Each channel owns one configuration byte that software writes over a simple register bus. The byte selects which source drives the channel, turns the channel on, and, on the lowest channels only, switches the channel into trigger-gated mode.

Source number 0 is a dead selection. The top few source numbers are "always active" sources. Routing one of them to an enabled channel keeps that channel's request high, so the DMA engine restarts its transfer without the processor. If trigger mode is also on, the same source yields exactly one request per timer trigger edge, and the DMA engine's acknowledge closes each request. This gives periodic packet transfers with no software in the loop.

The configuration byte uses these fields: bit 7 is enable, bit 6 is trigger mode, and bits 5:0 are the source number. Channel n's byte sits at register offset n. With the default parameters there are 8 channels, 64 source numbers, trigger capability on channels 0 to 3, and always-active sources 60 to 63.

Top module: `dma_req_router`

## Requirements
- R1: After reset every configuration byte reads 0x00 and every channel request output is low.
- R2: A write at offset n (n below the channel count) stores the full byte in channel n's configuration. A read at offset n returns the last byte written there, including bits that have no effect on that channel.
- R3: A write at an offset at or above the channel count changes no configuration byte and no request output. A read at such an offset returns 0x00.
- R4: An enabled channel with trigger mode off, whose source number is between 1 and 59, drives its request equal to that source's request line in the same cycle.
- R5: An enabled channel selecting source 0 never requests, whatever the source lines do.
- R6: An enabled channel with trigger mode off that selects source 60, 61, 62 or 63 holds its request high on every cycle, with no source activity.
- R7: A channel whose enable bit (bit 7) is 0 keeps its request low, whatever its source and trigger settings.
- R8: On channels 0 to 3 with enable and trigger mode set, a rising edge on the channel's trigger input sets a pending flag at the next clock edge. The request is high while the flag is set and the selected source is active. An acknowledge from the DMA engine for that channel clears the flag at the next clock edge.
- R9: On channels 4 and above, the trigger-mode bit (bit 6) has no effect: the channel behaves as with trigger mode off.
- R10: Clearing a channel's enable bit discards any pending trigger, so re-enabling the channel does not raise a request until a new trigger edge arrives.
- R11: A trigger input held high produces only one pending request. After that request is acknowledged, the channel stays idle until the trigger input falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register offset (channel number) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| src_req | input | 64 | Peripheral request lines, indexed by source number |
| trig_in | input | NUM_TRIG_CH | Periodic trigger inputs for the trigger-capable channels |
| dma_ack | input | NUM_CH | Per-channel acknowledge from the DMA engine |
| ch_req | output | NUM_CH | Per-channel request to the DMA engine |

## Verification
Routing is driven with all source lines low, a single line high, and all lines high. This separates a correct source select from a stuck, inverted or ignored select, and it shows that source 0 and disabled channels stay quiet even under full activity. Always-active sources are tried both with and without trigger mode, and on a channel with trigger capability and on one without. This tells continuous re-activation apart from gated re-activation and exposes a trigger bit that leaks onto upper channels. Trigger stimuli are a one-cycle pulse, a level held high across an acknowledge, and a pulse followed by disable and re-enable. These distinguish edge from level detection, acknowledge clearing, and clearing of the pending flag on disable. Out-of-range writes followed by read-back catch address aliasing.

// File: rtl/dmux_pkg.sv
package dmux_pkg;
    localparam int CFG_W   = 8;
    localparam int SEL_W   = 6;
    localparam int NUM_SRC = 2 ** SEL_W;

    typedef struct packed {
        logic             en;
        logic             trg;
        logic [SEL_W-1:0] sel;
    } ch_cfg_t;
endpackage

// File: rtl/dmux_regfile.sv
module dmux_regfile
    import dmux_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [CFG_W-1:0]            bus_wdata,
    output logic [CFG_W-1:0]            bus_rdata,
    output logic [NUM_CH-1:0][CFG_W-1:0] cfg_o
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic [NUM_CH-1:0][CFG_W-1:0] cfg;
    } rf_state_t;

    rf_state_t st_d, st_q;
    logic       in_range;
    logic [IDX_W-1:0] idx;

    assign idx      = bus_addr[IDX_W-1:0];
    assign in_range = (bus_addr < ADDR_W'(NUM_CH));

    always_comb begin
        st_d = st_q;
        if (bus_wr && in_range) begin
            st_d.cfg[idx] = bus_wdata;
        end
        bus_rdata = in_range ? st_q.cfg[idx] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.cfg;

    // R2: an in-range write lands in the addressed byte
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && in_range) |=> (st_q.cfg[$past(idx)] == $past(bus_wdata)));

    // R3: out-of-range writes leave the storage untouched
    a_r3_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !in_range) |=> $stable(st_q.cfg));

    // R3: reads beyond the channel count return zero
    a_r3_oob_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |-> (bus_rdata == '0));
endmodule

// File: rtl/dmux_channel.sv
module dmux_channel
    import dmux_pkg::*;
#(
    parameter bit HAS_TRIG   = 1'b1,
    parameter int NUM_ALWAYS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CFG_W-1:0]   cfg_byte,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               trig,
    input  logic               ack,
    output logic               req
);
    localparam int ALW_BASE = NUM_SRC - NUM_ALWAYS;

    typedef struct packed {
        logic pend;
        logic trig_prev;
    } ch_state_t;

    ch_state_t st_d, st_q;
    ch_cfg_t   cfg;
    logic      src_active;
    logic      trig_mode;
    logic      rise;

    assign cfg = ch_cfg_t'(cfg_byte);

    generate
        if (HAS_TRIG) begin : g_trig
            assign trig_mode = cfg.trg;
        end else begin : g_notrig
            assign trig_mode = 1'b0;
        end
    endgenerate

    always_comb begin
        if (cfg.sel == '0) begin
            src_active = 1'b0;
        end else if (int'(cfg.sel) >= ALW_BASE) begin
            src_active = 1'b1;
        end else begin
            src_active = src_req[cfg.sel];
        end
    end

    always_comb begin
        st_d           = st_q;
        rise           = trig && !st_q.trig_prev;
        st_d.trig_prev = trig;
        if (!cfg.en || !trig_mode) begin
            st_d.pend = 1'b0;
        end else if (rise) begin
            st_d.pend = 1'b1;
        end else if (ack) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (!cfg.en) begin
            req = 1'b0;
        end else if (trig_mode) begin
            req = st_q.pend && src_active;
        end else begin
            req = src_active;
        end
    end

    // R7: a disabled channel never requests
    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |-> !req);

    // R10: disabling discards the pending trigger
    a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> !st_q.pend);

    // R8 / R11: pending is only raised by a fresh trigger edge
    a_r11_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend) |-> $past(trig && !st_q.trig_prev));

    // R6: an always-active source keeps an untriggered channel requesting
    a_r6_always_on: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && !trig_mode && int'(cfg.sel) >= ALW_BASE) |-> req);
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
    import dmux_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int NUM_TRIG_CH = 4,
    parameter int NUM_ALWAYS  = 4,
    parameter int ADDR_W      = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [CFG_W-1:0]       bus_wdata,
    output logic [CFG_W-1:0]       bus_rdata,
    input  logic [NUM_SRC-1:0]     src_req,
    input  logic [NUM_TRIG_CH-1:0] trig_in,
    input  logic [NUM_CH-1:0]      dma_ack,
    output logic [NUM_CH-1:0]      ch_req
);
    logic [NUM_CH-1:0][CFG_W-1:0] cfg_w;
    logic [NUM_CH-1:0]            trig_w;

    dmux_regfile #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_o     (cfg_w)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            if (g < NUM_TRIG_CH) begin : g_t
                assign trig_w[g] = trig_in[g];
            end else begin : g_nt
                assign trig_w[g] = 1'b0;
            end

            dmux_channel #(
                .HAS_TRIG   (g < NUM_TRIG_CH),
                .NUM_ALWAYS (NUM_ALWAYS)
            ) i_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .cfg_byte (cfg_w[g]),
                .src_req  (src_req),
                .trig     (trig_w[g]),
                .ack      (dma_ack[g]),
                .req      (ch_req[g])
            );
        end
    endgenerate

    // R1: nothing requests in the first cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (ch_req == '0));
endmodule

// File: tb/test_dma_req_router.sv
`timescale 1ns/1ps
module test_dma_req_router;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [63:0] src_req = '0;
    logic [3:0]  trig_in = '0;
    logic [7:0]  dma_ack = '0;
    logic [7:0]  ch_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit         is_read;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    dma_req_router i_dma_req_router (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_req(src_req),
        .trig_in(trig_in), .dma_ack(dma_ack), .ch_req(ch_req)
    );

    // monitor: compare queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                act = it.is_read ? bus_rdata : ch_req;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: %s actual %02h expected %02h", it.tag,
                             it.is_read ? "rdata" : "ch_req", act, it.exp);
                end
            end
        end
    end

    task automatic exp_req(input logic [7:0] e, input string tag);
        item_t it;
        it.is_read = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic exp_read(input logic [3:0] a, input logic [7:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.is_read = 1'b1; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic pulse_trig(input int ch);
        trig_in[ch] = 1'b1;
        @(posedge clk); #1;
        trig_in[ch] = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        exp_req(8'h00, "R1 requests after reset");
        for (int i = 0; i < NCH; i++) exp_read(4'(i), 8'h00, "R1 config after reset");

        // R2 / R4: program channel 2 to source 5
        wr(4'd2, 8'h85);
        exp_read(4'd2, 8'h85, "R2 readback ch2");
        exp_req(8'h00, "R4 source idle");
        src_req[5] = 1'b1;
        exp_req(8'h04, "R4 source active");
        src_req[5] = 1'b0;
        exp_req(8'h00, "R4 source drops");

        // R5 / R7 under full source activity
        wr(4'd1, 8'h80);
        wr(4'd3, 8'h05);
        src_req = '1;
        exp_req(8'h04, "R5 R7 all sources high");
        exp_read(4'd3, 8'h05, "R2 readback disabled ch3");

        // R3: out-of-range write
        wr(4'd9, 8'hFF);
        exp_read(4'd9, 8'h00, "R3 read beyond channels");
        exp_read(4'd1, 8'h80, "R3 no alias onto ch1");
        exp_req(8'h04, "R3 requests unchanged");
        src_req = '0;
        for (int i = 0; i < NCH; i++) wr(4'(i), 8'h00);
        exp_req(8'h00, "R7 all cleared");

        // R6: always-active source, channel 5
        wr(4'd5, 8'hBE);
        exp_req(8'h20, "R6 always source cycle 1");
        exp_req(8'h20, "R6 always source cycle 2");

        // R9: trigger bit on channel 6 has no effect
        wr(4'd6, 8'hFC);
        exp_req(8'h60, "R9 trigger bit ignored ch6");
        exp_read(4'd6, 8'hFC, "R2 readback ch6");

        // R8: trigger-gated always source on channel 0
        wr(4'd0, 8'hFD);
        exp_req(8'h60, "R8 no trigger yet");
        trig_in[0] = 1'b1;
        exp_req(8'h60, "R8 edge not yet registered");
        trig_in[0] = 1'b0;
        exp_req(8'h61, "R8 pending after edge");
        exp_req(8'h61, "R8 pending held");
        dma_ack[0] = 1'b1;
        exp_req(8'h61, "R8 during ack");
        dma_ack[0] = 1'b0;
        exp_req(8'h60, "R8 cleared by ack");

        // R8: trigger-gated ordinary source on channel 1
        wr(4'd1, 8'hC7);
        pulse_trig(1);
        exp_req(8'h60, "R8 pending but source idle");
        src_req[7] = 1'b1;
        exp_req(8'h62, "R8 pending and source active");
        dma_ack[1] = 1'b1;
        exp_req(8'h62, "R8 ch1 during ack");
        dma_ack[1] = 1'b0;
        exp_req(8'h60, "R8 ch1 cleared by ack");
        src_req[7] = 1'b0;

        // R11: held trigger yields a single request
        trig_in[0] = 1'b1;
        exp_req(8'h60, "R11 level seen");
        exp_req(8'h61, "R11 one pending");
        dma_ack[0] = 1'b1;
        exp_req(8'h61, "R11 ack while held");
        dma_ack[0] = 1'b0;
        exp_req(8'h60, "R11 no re-arm while held");
        exp_req(8'h60, "R11 still idle");
        trig_in[0] = 1'b0;
        exp_req(8'h60, "R11 after release");

        // R10: disable discards pending
        pulse_trig(0);
        exp_req(8'h61, "R10 pending set");
        wr(4'd0, 8'h00);
        exp_req(8'h60, "R10 disabled quiet");
        wr(4'd0, 8'hFD);
        exp_req(8'h60, "R10 no stale request after re-enable");
        pulse_trig(0);
        exp_req(8'h61, "R10 new edge requests again");

        @(posedge clk); #1;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule